// File: doc/BRIEF.md
# Dual-Port Static Memory with Same-Address Contention Arbiter

This block is a clocked model of a 2048-byte memory that two independent agents share through a left and a right port. Each port has an active-low select, a write strobe (low for write, high for read), an active-low output enable, an 11-bit address and separate 8-bit write and read data. Accesses to different locations on the two sides complete independently in the same cycle.

When both ports are selected and present the same address, an arbiter grants the location to one side. It pulls the other side's active-low busy output low, and the losing side's reads and writes are then ignored. A port counts as "earlier" when it already held its selected state and address on the previous clock. This one rule settles both orderings. If the addresses matched before the selects arrived, the port selected first wins. If both sides were selected before the addresses met, the port whose address did not move wins. A same-cycle tie goes to the left port. The grant is held until the match ends, and the waiting side then proceeds in that same cycle.

A parameter switches the block into slave mode, which is used when several devices are placed side by side to widen the data bus. In slave mode the block does not arbitrate: each port takes a busy input from a master device, suppresses its accesses while that input is low, and waits a parameterised number of settle cycles after an address is presented before it lets a write through.

Top module: `dp_contention_ram`

## Requirements
- R1: A selected port (select low) with the write strobe low and no block writes its data to the addressed byte at the clock edge. With the strobe high, it loads that byte onto its read data at the clock edge. Read data holds its value between reads.
- R2: A port whose select is high performs no read or write, and no busy output is low while either select is high.
- R3: A port's drive indicator is high only while the port is selected, its write strobe is high and its output enable is low.
- R4: When both ports are selected at different addresses, neither busy output goes low and both accesses complete in the same cycle.
- R5: If the addresses already match and the selects go low on different cycles, the port selected first wins and the other port's busy output goes low in the cycle it selects.
- R6: If both ports are already selected and one moves its address onto the other's, the port whose address was held wins and the mover's busy output goes low.
- R7: If both ports start the same-address access in the same cycle, so that neither held its state on the previous clock, the left port wins.
- R8: A losing port's write does not change memory and its read data holds its value. A grant stays with its winner for as long as the match lasts, even after the loser has held its address too.
- R9: In the first cycle in which the match ends, both busy outputs are high and a waiting port's access completes in that cycle.
- R10: In slave mode both busy outputs stay high, and a port's reads and writes are suppressed while its busy input is low.
- R11: In slave mode a write takes effect only once the port has kept its select and address for SETTLE cycles (default 2). A write strobe still held low when the busy input returns high then completes.
- R12: After reset the read data of both ports is zero and both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left strobe: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_drive | output | 1 | Left data drivers enabled |
| l_busy_n_i | input | 1 | Left busy from a master (slave mode) |
| l_busy_n_o | output | 1 | Left busy, active low (master mode) |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right strobe: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_drive | output | 1 | Right data drivers enabled |
| r_busy_n_i | input | 1 | Right busy from a master (slave mode) |
| r_busy_n_o | output | 1 | Right busy, active low (master mode) |

## Verification
The arbiter is tried with collisions where the addresses match before the selects go low on different cycles, collisions where the selects are low first and one address moves onto the other, and same-cycle starts. Between them these tell apart whether the grant follows the earlier select, the held address, or the left-side tie break. Further sequences check that a grant persists once both sides are steady, that a loser's write and read leave memory and read data untouched, and that a waiting write lands as soon as the winner leaves. The slave device is driven with write bursts one cycle shorter than the settle time, with its busy input held low, and with its busy input released while the strobe is still held. These show separately that settle gating, busy gating and completion after release each work.

// File: rtl/dp_contention_ram.sv
module dp_contention_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter bit IS_SLAVE = 1'b0,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_drive,
  input  logic          l_busy_n_i,
  output logic          l_busy_n_o,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_drive,
  input  logic          r_busy_n_i,
  output logic          r_busy_n_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(SETTLE + 2);
  localparam logic [CW-1:0] SET_V = CW'(SETTLE);

  typedef enum logic [1:0] {OWN_NONE, OWN_L, OWN_R} own_t;

  logic [DW-1:0] mem [DEPTH];
  own_t owner, win;
  logic sel_l, sel_r, sel_lq, sel_rq;
  logic [AW-1:0] addr_lq, addr_rq;
  logic stable_l, stable_r, match;
  logic m_busy_l, m_busy_r;
  logic [CW-1:0] cnt_l, cnt_r, eff_l, eff_r;
  logic ok_l, ok_r, settled_l, settled_r;
  logic wr_l, wr_r, rd_l, rd_r;

  assign sel_l = ~l_cs_n;
  assign sel_r = ~r_cs_n;
  assign stable_l = sel_l & sel_lq & (l_addr == addr_lq);
  assign stable_r = sel_r & sel_rq & (r_addr == addr_rq);
  assign match = sel_l & sel_r & (l_addr == r_addr);

  always_comb begin
    if (owner != OWN_NONE)          win = owner;
    else if (stable_r && !stable_l) win = OWN_R;
    else                            win = OWN_L;
  end

  assign m_busy_l = match & (win == OWN_R);
  assign m_busy_r = match & (win == OWN_L);

  assign l_busy_n_o = IS_SLAVE ? 1'b1 : ~m_busy_l;
  assign r_busy_n_o = IS_SLAVE ? 1'b1 : ~m_busy_r;

  assign eff_l = stable_l ? cnt_l : '0;
  assign eff_r = stable_r ? cnt_r : '0;
  assign ok_l = IS_SLAVE ? l_busy_n_i : ~m_busy_l;
  assign ok_r = IS_SLAVE ? r_busy_n_i : ~m_busy_r;
  assign settled_l = IS_SLAVE ? (eff_l == SET_V) : 1'b1;
  assign settled_r = IS_SLAVE ? (eff_r == SET_V) : 1'b1;

  assign wr_l = sel_l & ~l_we_n & ok_l & settled_l;
  assign wr_r = sel_r & ~r_we_n & ok_r & settled_r;
  assign rd_l = sel_l & l_we_n & ok_l;
  assign rd_r = sel_r & r_we_n & ok_r;

  assign l_drive = sel_l & l_we_n & ~l_oe_n;
  assign r_drive = sel_r & r_we_n & ~r_oe_n;

  always_ff @(posedge clk) begin
    if (wr_r) mem[r_addr] <= r_wdata;
    if (wr_l) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner   <= OWN_NONE;
      sel_lq  <= 1'b0;
      sel_rq  <= 1'b0;
      addr_lq <= '0;
      addr_rq <= '0;
      cnt_l   <= '0;
      cnt_r   <= '0;
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      owner   <= match ? win : OWN_NONE;
      sel_lq  <= sel_l;
      sel_rq  <= sel_r;
      addr_lq <= l_addr;
      addr_rq <= r_addr;
      cnt_l   <= (eff_l == SET_V) ? eff_l : eff_l + 1'b1;
      cnt_r   <= (eff_r == SET_V) ? eff_r : eff_r + 1'b1;
      if (rd_l) l_rdata <= mem[l_addr];
      if (rd_r) r_rdata <= mem[r_addr];
    end
  end

  p_one_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_n_o || r_busy_n_o));

  p_idle_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n || r_cs_n) |-> (l_busy_n_o && r_busy_n_o));

  p_hold_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_SLAVE && !l_busy_n_o) |=> $stable(l_rdata));

  p_hold_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_SLAVE && !r_busy_n_o) |=> $stable(r_rdata));

  p_grant_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && match && $past(match) && !$past(l_busy_n_o)) |-> !l_busy_n_o);

  p_slave_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SLAVE && !r_busy_n_i) |=> $stable(r_rdata));
endmodule

// File: tb/sim_dp_contention_ram.sv
module sim_dp_contention_ram;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic l_cs_n, l_we_n, l_oe_n, r_cs_n, r_we_n, r_oe_n;
  logic [10:0] l_addr, r_addr;
  logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_drive, r_drive, l_bo, r_bo;

  logic sl_cs_n, sl_we_n, sr_cs_n, sr_we_n, sl_bi, sr_bi;
  logic [10:0] sl_addr, sr_addr;
  logic [7:0] sl_wdata, sl_rdata, sr_rdata;
  logic sl_drive, sr_drive, sl_bo, sr_bo;

  dp_contention_ram u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
    .l_busy_n_i(1'b1), .l_busy_n_o(l_bo),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive),
    .r_busy_n_i(1'b1), .r_busy_n_o(r_bo));

  dp_contention_ram #(.IS_SLAVE(1'b1), .SETTLE(2)) u1 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(sl_cs_n), .l_we_n(sl_we_n), .l_oe_n(1'b0), .l_addr(sl_addr),
    .l_wdata(sl_wdata), .l_rdata(sl_rdata), .l_drive(sl_drive),
    .l_busy_n_i(sl_bi), .l_busy_n_o(sl_bo),
    .r_cs_n(sr_cs_n), .r_we_n(sr_we_n), .r_oe_n(1'b0), .r_addr(sr_addr),
    .r_wdata(8'h00), .r_rdata(sr_rdata), .r_drive(sr_drive),
    .r_busy_n_i(sr_bi), .r_busy_n_o(sr_bo));

  typedef struct packed {
    logic csl; logic wel; logic [10:0] al; logic [7:0] dl;
    logic csr; logic wer; logic [10:0] ar; logic [7:0] dr;
    logic bl; logic br;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h010,8'hA1, 1'b0,1'b0,11'h020,8'hB2, 1'b1,1'b1},
    '{1'b0,1'b0,11'h030,8'hC3, 1'b1,1'b1,11'h030,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h030,8'hC4, 1'b0,1'b0,11'h030,8'h5A, 1'b1,1'b0},
    '{1'b0,1'b0,11'h030,8'hC5, 1'b0,1'b0,11'h030,8'h5B, 1'b1,1'b0},
    '{1'b1,1'b1,11'h030,8'h00, 1'b0,1'b0,11'h030,8'h5C, 1'b1,1'b1},
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b0,1'b1,11'h040,8'h00, 1'b0,1'b1,11'h041,8'h00, 1'b1,1'b1},
    '{1'b0,1'b1,11'h040,8'h00, 1'b0,1'b1,11'h040,8'h00, 1'b1,1'b0},
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b0,1'b1,11'h050,8'h00, 1'b0,1'b1,11'h060,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h060,8'h77, 1'b0,1'b1,11'h060,8'h00, 1'b0,1'b1},
    '{1'b0,1'b0,11'h060,8'h78, 1'b1,1'b1,11'h060,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h070,8'h0F, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b1,1'b1,11'h070,8'h00, 1'b0,1'b1,11'h070,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h070,8'h99, 1'b0,1'b1,11'h070,8'h00, 1'b0,1'b1},
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h080,8'h11, 1'b0,1'b0,11'h080,8'h22, 1'b1,1'b0},
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1},
    '{1'b0,1'b1,11'h090,8'h00, 1'b0,1'b1,11'h091,8'h00, 1'b1,1'b1},
    '{1'b0,1'b0,11'h092,8'h33, 1'b0,1'b0,11'h092,8'h44, 1'b1,1'b0},
    '{1'b0,1'b0,11'h092,8'h35, 1'b0,1'b0,11'h092,8'h45, 1'b1,1'b0},
    '{1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1}
  };

  int checks = 0, fails = 0;
  logic [7:0] ref_m [2048];

  function automatic string row_tag(int i);
    case (i)
      1: return "R4";
      2, 13: return "R1";
      3, 4, 15: return "R5";
      5, 12: return "R9";
      8, 11: return "R6";
      17, 20: return "R7";
      21: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic m_set(logic csl, logic wel, logic [10:0] al, logic [7:0] dl,
                       logic csr, logic wer, logic [10:0] ar, logic [7:0] dr);
    l_cs_n = csl; l_we_n = wel; l_addr = al; l_wdata = dl;
    r_cs_n = csr; r_we_n = wer; r_addr = ar; r_wdata = dr;
  endtask

  task automatic m_readl(logic [10:0] a, string tag);
    m_set(1'b0, 1'b1, a, 8'h00, 1'b1, 1'b1, 11'h000, 8'h00);
    tick();
    chk(tag, l_rdata, ref_m[a]);
  endtask

  task automatic s_write(logic [10:0] a, logic [7:0] d, int n, logic bi);
    for (int k = 0; k < n; k++) begin
      sl_cs_n = 1'b0; sl_we_n = 1'b0; sl_addr = a; sl_wdata = d; sl_bi = bi;
      tick();
    end
    sl_cs_n = 1'b1; sl_we_n = 1'b1; sl_bi = 1'b1;
    tick();
  endtask

  task automatic s_read(logic [10:0] a, logic bi);
    sr_cs_n = 1'b0; sr_we_n = 1'b1; sr_addr = a; sr_bi = bi;
    tick();
    sr_cs_n = 1'b1; sr_bi = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    m_set(1'b1, 1'b1, 11'h000, 8'h00, 1'b1, 1'b1, 11'h000, 8'h00);
    sl_cs_n = 1'b1; sl_we_n = 1'b1; sl_addr = '0; sl_wdata = '0; sl_bi = 1'b1;
    sr_cs_n = 1'b1; sr_we_n = 1'b1; sr_addr = '0; sr_bi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 l_rdata", l_rdata, 8'h00);
    chk("R12 r_rdata", r_rdata, 8'h00);
    chk("R12 busy", {l_bo, r_bo}, 2'b11);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      m_set(VEC[i].csl, VEC[i].wel, VEC[i].al, VEC[i].dl,
            VEC[i].csr, VEC[i].wer, VEC[i].ar, VEC[i].dr);
      #1;
      chk($sformatf("%s row %0d busy", row_tag(i), i), {l_bo, r_bo}, {VEC[i].bl, VEC[i].br});
      if (!VEC[i].csl && !VEC[i].wel && VEC[i].bl) ref_m[VEC[i].al] = VEC[i].dl;
      if (!VEC[i].csr && !VEC[i].wer && VEC[i].br) ref_m[VEC[i].ar] = VEC[i].dr;
      tick();
    end

    // R2: deselected port with write strobe low writes nothing
    m_set(1'b1, 1'b0, 11'h010, 8'hFF, 1'b1, 1'b0, 11'h020, 8'hEE);
    tick();
    m_readl(11'h010, "R2 deselected write ignored L");
    m_readl(11'h020, "R2 deselected write ignored R");
    m_readl(11'h030, "R9 waiting write landed");
    m_readl(11'h060, "R9 write after winner left");
    m_readl(11'h070, "R8 loser write ignored");
    m_readl(11'h080, "R7 tie left wins");
    m_readl(11'h092, "R8 grant kept");
    chk("R1 value A1 at 0x010", ref_m[11'h010], 8'hA1);

    // R3: drive follows select, strobe and enable
    m_set(1'b0, 1'b1, 11'h010, 8'h00, 1'b0, 1'b0, 11'h300, 8'h01);
    l_oe_n = 1'b1; #1;
    chk("R3 oe high no drive", l_drive, 1'b0);
    l_oe_n = 1'b0; #1;
    chk("R3 read drive", l_drive, 1'b1);
    chk("R3 write no drive", r_drive, 1'b0);
    tick();

    // R8: loser read holds its data
    m_set(1'b0, 1'b0, 11'h100, 8'hAB, 1'b0, 1'b0, 11'h101, 8'hCD);
    tick();
    m_set(1'b1, 1'b1, 11'h000, 8'h00, 1'b0, 1'b1, 11'h101, 8'h00);
    tick();
    chk("R1 right read", r_rdata, 8'hCD);
    m_set(1'b0, 1'b1, 11'h100, 8'h00, 1'b1, 1'b1, 11'h000, 8'h00);
    tick();
    m_set(1'b0, 1'b1, 11'h100, 8'h00, 1'b0, 1'b1, 11'h100, 8'h00);
    #1;
    chk("R5 read collision busy", {l_bo, r_bo}, 2'b10);
    tick();
    chk("R8 loser read held", r_rdata, 8'hCD);
    chk("R1 winner read", l_rdata, 8'hAB);
    m_set(1'b1, 1'b1, 11'h000, 8'h00, 1'b1, 1'b1, 11'h000, 8'h00);
    tick();

    // Slave device
    chk("R10 slave busy out high", {sl_bo, sr_bo}, 2'b11);
    s_write(11'h200, 8'h5E, 3, 1'b1);
    s_read(11'h200, 1'b1);
    chk("R11 write after settle", sr_rdata, 8'h5E);
    s_write(11'h200, 8'hE1, 2, 1'b1);
    s_read(11'h200, 1'b1);
    chk("R11 short write suppressed", sr_rdata, 8'h5E);
    s_write(11'h200, 8'hE2, 4, 1'b0);
    s_read(11'h200, 1'b1);
    chk("R10 write under busy suppressed", sr_rdata, 8'h5E);
    for (int k = 0; k < 3; k++) begin
      sl_cs_n = 1'b0; sl_we_n = 1'b0; sl_addr = 11'h200; sl_wdata = 8'hE2; sl_bi = 1'b0;
      tick();
    end
    s_write(11'h200, 8'hE2, 1, 1'b1);
    s_read(11'h200, 1'b1);
    chk("R11 held strobe completes", sr_rdata, 8'hE2);
    s_write(11'h201, 8'h3C, 3, 1'b1);
    s_read(11'h201, 1'b0);
    chk("R10 read under busy suppressed", sr_rdata, 8'hE2);
    s_read(11'h201, 1'b1);
    chk("R10 read after release", sr_rdata, 8'h3C);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule